// File: doc/BRIEF.md
# Load/Store Data Sizing Unit

This combinational unit sits between a 32-bit register file and a data memory port that is byte addressed and 32 bits wide. Consecutive words in that memory are four addresses apart, so the two low address bits pick a byte lane inside the word. Byte lanes are little-endian: lane 0 holds bits 7:0, and address bit 1 picks the upper halfword.

On a store, the unit takes the register value, an access size and the low address bits. It produces a 4-bit byte-enable mask and write data that is already placed on the right lanes. On a load, it takes the returned memory word, picks out the addressed byte or halfword, and extends it to 32 bits with zeros or with its sign bit. The unit flags any access whose address is not a multiple of its size. A flagged access writes nothing and returns zero.

Top module: `ldst_sizer`

## Requirements
- R1: The size code is 2'b00 for a byte, 2'b01 for a halfword and 2'b10 for a word. A byte store drives `mem_be` = 4'b0001 shifted left by `addr_lo`.
- R2: An aligned halfword store (`addr_lo[0]`=0) drives `mem_be` = 4'b0011 shifted left by `addr_lo`.
- R3: An aligned word store (`addr_lo`=2'b00) drives `mem_be` = 4'b1111.
- R4: Store write data carries the low byte in all four lanes for a byte store, the low halfword in both halves for a halfword store, and the register value unchanged for a word store.
- R5: An unsigned byte load (`load_signed`=0) returns the byte at bits 8*`addr_lo`+7 down to 8*`addr_lo` of `mem_rdata`, with bits 31:8 set to zero.
- R6: A signed byte load (`load_signed`=1) fills bits 31:8 with bit 7 of the selected byte.
- R7: A halfword load returns `mem_rdata[31:16]` when `addr_lo[1]`=1 and `mem_rdata[15:0]` otherwise. Bits 31:16 of the result are zero for an unsigned load and copies of bit 15 of the halfword for a signed load.
- R8: A word load returns `mem_rdata` unchanged, whatever the value of `load_signed`.
- R9: `misalign` is 1 for a halfword access with `addr_lo[0]`=1 and for a word access with `addr_lo` not equal to 2'b00. It is 0 for every byte access.
- R10: Size code 2'b11 is unsupported and always raises `misalign`.
- R11: While `misalign` is 1, `mem_be` is 4'b0000 and `ld_result` is zero.
- R12: A load (`is_store`=0) never drives any byte enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| is_store | input | 1 | 1 for a store, 0 for a load |
| size | input | 2 | Access size code (see R1) |
| load_signed | input | 1 | Sign-extend a byte or halfword load |
| addr_lo | input | 2 | Low two bits of the byte address |
| st_reg | input | 32 | Register value to store |
| mem_rdata | input | 32 | Word read back from memory |
| mem_be | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Lane-placed store data |
| ld_result | output | 32 | Extended load result |
| misalign | output | 1 | Alignment or size fault |

## Verification
The bench walks byte and halfword accesses through every lane. A design with a swapped lane order or a wrong shift would enable the wrong byte on a store, or return a neighbouring byte on a load. Load patterns are chosen so that the top bit of the selected item differs from the top bits of the memory word. An extension that takes its fill bit from the wrong place then shows up as a wrong upper result.

The bench also tries every misaligned address for halfword and word accesses, and the unsupported size code. A design that decides alignment from the wrong address bit would either write memory on a bad access or fault on a good one. Word loads are run with the signed flag set to catch any extension wrongly applied to full words.

// File: rtl/ldst_sizer.sv
module ldst_sizer (
  input  logic        is_store,
  input  logic [1:0]  size,
  input  logic        load_signed,
  input  logic [1:0]  addr_lo,
  input  logic [31:0] st_reg,
  input  logic [31:0] mem_rdata,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  output logic [31:0] ld_result,
  output logic        misalign
);

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  logic [3:0]  lane_mask;
  logic [7:0]  pick_b;
  logic [15:0] pick_h;
  logic [31:0] ext;

  always_comb begin
    case (size)
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = addr_lo[0];
      SZ_WORD: misalign = |addr_lo;
      default: misalign = 1'b1;
    endcase
  end

  always_comb begin
    case (size)
      SZ_BYTE: lane_mask = 4'b0001 << addr_lo;
      SZ_HALF: lane_mask = 4'b0011 << addr_lo;
      SZ_WORD: lane_mask = 4'b1111;
      default: lane_mask = 4'b0000;
    endcase
  end

  assign mem_be = (is_store && !misalign) ? lane_mask : 4'b0000;

  always_comb begin
    case (size)
      SZ_BYTE: mem_wdata = {4{st_reg[7:0]}};
      SZ_HALF: mem_wdata = {2{st_reg[15:0]}};
      default: mem_wdata = st_reg;
    endcase
  end

  always_comb begin
    case (addr_lo)
      2'd0:    pick_b = mem_rdata[7:0];
      2'd1:    pick_b = mem_rdata[15:8];
      2'd2:    pick_b = mem_rdata[23:16];
      default: pick_b = mem_rdata[31:24];
    endcase
  end

  assign pick_h = addr_lo[1] ? mem_rdata[31:16] : mem_rdata[15:0];

  always_comb begin
    case (size)
      SZ_BYTE: ext = {{24{load_signed & pick_b[7]}}, pick_b};
      SZ_HALF: ext = {{16{load_signed & pick_h[15]}}, pick_h};
      default: ext = mem_rdata;
    endcase
  end

  assign ld_result = misalign ? 32'd0 : ext;

endmodule

// File: rtl/ldst_sizer_chk.sv
module ldst_sizer_chk (
  input logic        is_store,
  input logic [1:0]  size,
  input logic        load_signed,
  input logic [1:0]  addr_lo,
  input logic [31:0] mem_rdata,
  input logic [3:0]  mem_be,
  input logic [31:0] ld_result,
  input logic        misalign
);
  always_comb begin
    if (misalign) p_no_write_on_fault_r11: assert (mem_be == 4'b0000);
    if (misalign) p_zero_result_on_fault_r11: assert (ld_result == 32'd0);
    if (!is_store) p_load_no_enable_r12: assert (mem_be == 4'b0000);
    if (size == 2'b00) p_byte_never_faults_r9: assert (!misalign);
    if (size == 2'b11) p_bad_size_faults_r10: assert (misalign);
    if (is_store && size == 2'b00) p_byte_one_lane_r1: assert ($countones(mem_be) == 1);
    if (size == 2'b00 && !load_signed) p_ubyte_upper_zero_r5: assert (ld_result[31:8] == 24'd0);
    if (size == 2'b00 && load_signed) p_sbyte_fill_r6: assert (ld_result[31:8] == {24{ld_result[7]}});
    if (size == 2'b10 && !misalign) p_word_pass_r8: assert (ld_result == mem_rdata);
    if (is_store && size == 2'b10 && addr_lo == 2'b00) p_word_all_lanes_r3: assert (mem_be == 4'b1111);
  end
endmodule

bind ldst_sizer ldst_sizer_chk u_chk (
  .is_store(is_store), .size(size), .load_signed(load_signed), .addr_lo(addr_lo),
  .mem_rdata(mem_rdata), .mem_be(mem_be), .ld_result(ld_result), .misalign(misalign)
);

// File: tb/ldst_sizer_tb.sv
`timescale 1ns/1ps
module ldst_sizer_tb;
  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  logic        is_store, load_signed, misalign;
  logic [1:0]  size, addr_lo;
  logic [31:0] st_reg, mem_rdata, mem_wdata, ld_result;
  logic [3:0]  mem_be;

  int total = 0;
  int bad = 0;
  bit done = 0;

  ldst_sizer u_dut (
    .is_store(is_store), .size(size), .load_signed(load_signed), .addr_lo(addr_lo),
    .st_reg(st_reg), .mem_rdata(mem_rdata), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .ld_result(ld_result), .misalign(misalign)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic drive(input logic st, input logic [1:0] sz, input logic sg,
                       input logic [1:0] a, input logic [31:0] r, input logic [31:0] m);
    @(negedge clk);
    is_store = st; size = sz; load_signed = sg; addr_lo = a; st_reg = r; mem_rdata = m;
    #1;
  endtask

  task automatic t_reset;
    drive(0, 2'b10, 0, 2'd0, 32'h0, 32'h0);
    chk("R12 idle be", {28'd0, mem_be}, 32'd0);
    chk("R9 idle fault", {31'd0, misalign}, 32'd0);
  endtask

  task automatic t_store_byte;
    for (int a = 0; a < 4; a++) begin
      drive(1, 2'b00, 0, a[1:0], 32'h1234_56A7, 32'h0);
      chk("R1 byte be", {28'd0, mem_be}, 32'd1 << a);
      chk("R4 byte data", mem_wdata, 32'hA7A7_A7A7);
      chk("R9 byte no fault", {31'd0, misalign}, 32'd0);
    end
  endtask

  task automatic t_store_half;
    for (int a = 0; a < 4; a++) begin
      drive(1, 2'b01, 0, a[1:0], 32'hDEAD_8C31, 32'h0);
      if (a % 2 == 0) begin
        chk("R2 half be", {28'd0, mem_be}, 32'd3 << a);
        chk("R4 half data", mem_wdata, 32'h8C31_8C31);
        chk("R9 half aligned", {31'd0, misalign}, 32'd0);
      end else begin
        chk("R9 half odd fault", {31'd0, misalign}, 32'd1);
        chk("R11 half odd be", {28'd0, mem_be}, 32'd0);
      end
    end
  endtask

  task automatic t_store_word;
    for (int a = 0; a < 4; a++) begin
      drive(1, 2'b10, 0, a[1:0], 32'hCAFE_F00D, 32'h0);
      if (a == 0) begin
        chk("R3 word be", {28'd0, mem_be}, 32'hF);
        chk("R4 word data", mem_wdata, 32'hCAFE_F00D);
      end else begin
        chk("R9 word fault", {31'd0, misalign}, 32'd1);
        chk("R11 word be", {28'd0, mem_be}, 32'd0);
      end
    end
  endtask

  task automatic t_load_byte;
    logic [31:0] m;
    logic [7:0] b;
    m = 32'h80_7F_C3_15;
    for (int a = 0; a < 4; a++) begin
      b = m[8*a +: 8];
      drive(0, 2'b00, 0, a[1:0], 32'h0, m);
      chk("R5 ubyte", ld_result, {24'd0, b});
      chk("R12 load be", {28'd0, mem_be}, 32'd0);
      drive(0, 2'b00, 1, a[1:0], 32'h0, m);
      chk("R6 sbyte", ld_result, {{24{b[7]}}, b});
    end
  endtask

  task automatic t_load_half;
    logic [31:0] m;
    logic [15:0] h;
    m = 32'h7F01_9234;
    for (int a = 0; a < 4; a += 2) begin
      h = (a == 2) ? m[31:16] : m[15:0];
      drive(0, 2'b01, 0, a[1:0], 32'h0, m);
      chk("R7 uhalf", ld_result, {16'd0, h});
      drive(0, 2'b01, 1, a[1:0], 32'h0, m);
      chk("R7 shalf", ld_result, {{16{h[15]}}, h});
    end
    drive(0, 2'b01, 1, 2'd3, 32'h0, m);
    chk("R11 half fault result", ld_result, 32'd0);
    chk("R9 half load fault", {31'd0, misalign}, 32'd1);
  endtask

  task automatic t_load_word;
    drive(0, 2'b10, 1, 2'd0, 32'h0, 32'h8000_00FF);
    chk("R8 word signed", ld_result, 32'h8000_00FF);
    drive(0, 2'b10, 0, 2'd0, 32'h0, 32'h1357_9BDF);
    chk("R8 word unsigned", ld_result, 32'h1357_9BDF);
    drive(0, 2'b10, 0, 2'd2, 32'h0, 32'h1357_9BDF);
    chk("R11 word fault result", ld_result, 32'd0);
  endtask

  task automatic t_bad_size;
    for (int a = 0; a < 4; a++) begin
      drive(1, 2'b11, 0, a[1:0], 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      chk("R10 bad size fault", {31'd0, misalign}, 32'd1);
      chk("R11 bad size be", {28'd0, mem_be}, 32'd0);
    end
  endtask

  initial begin
    is_store = 0; size = 2'b10; load_signed = 0; addr_lo = 0; st_reg = 0; mem_rdata = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    t_reset();
    t_store_byte();
    t_store_half();
    t_store_word();
    t_load_byte();
    t_load_half();
    t_load_word();
    t_bad_size();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog got=hung exp=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule